// File: doc/BRIEF.md
# Periodic Interrupt Divider

This block turns a 32768 Hz tick strobe into periodic interrupt events at a programmable power-of-two rate. A 15-bit counter advances by one on every tick and runs freely, whether or not events are enabled. A 4-bit rate code and an enable input choose when an event fires. Each event is a one-clock pulse in the system clock domain. A neighbouring flag register uses that pulse to set its interrupt-request and periodic status bits and to drive the interrupt line.

Events fall where the tick count reaches a multiple of the selected period. They are not timed from the moment the block is enabled, so turning the block on part-way through a period gives a short first interval. A change to the rate code or the enable applies from the next tick, with no settling delay.

Top module: `periodic_irq_divider`

## Requirements
- R1: A synchronous active-high reset clears the tick counter to zero and drives `eventOut` low. Ticks that arrive while reset is high are ignored, so after reset the first event for rate code 3 comes on the fourth tick.
- R2: A rate code of 0 produces no events, whatever the enable input is.
- R3: When `periodicEn` is low, no events are produced for any rate code.
- R4: A rate code c from 3 to 15, with the block enabled, gives one event every 2^(c-1) ticks.
- R5: Rate code 1 behaves like code 8 (a period of 128 ticks), and rate code 2 behaves like code 9 (a period of 256 ticks).
- R6: An event fires on the tick that brings the free-running count to a multiple of the period. The count used here is the number of ticks since reset, modulo 32768. The time at which the block was enabled plays no part.
- R7: `eventOut` is high for exactly the one clock cycle that follows the clock edge at which the qualifying tick was sampled. It is low in every cycle that does not follow a tick.
- R8: The tick counter is 15 bits wide, wraps from 32767 to 0, and counts whether or not events are enabled. With rate code 15, exactly two events fire in any run of 32768 consecutive ticks.
- R9: A new rate code or enable value applies at the very next tick, checked against the new period's boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tickIn | input | 1 | One-cycle strobe at 32768 Hz |
| rateCode | input | 4 | Rate select; 0 disables events; 1 and 2 alias to 8 and 9 |
| periodicEn | input | 1 | Periodic event enable |
| eventOut | output | 1 | One-clock periodic event pulse |

## Verification
The main function is driven in four ways. First come fixed runs at each short rate, which show whether the divisor decodes correctly for each code. Runs at codes 1 and 2 come next, and they separate the aliased divisors from a plain 2^(c-1) decode. An enable that is raised at an odd count shows whether events sit on the period boundary or are counted from the enable. A full 32768-tick run at the slowest rate shows whether the counter is 15 bits wide and wraps cleanly. Random segments change the code, the enable and the spacing between ticks, and an independent count model catches a change that applies late, an event that fires between ticks, and an event produced while the block is disabled.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int PID_CNT_W  = 15;
  localparam int PID_CODE_W = 4;
  localparam int PID_SPAN_W = $clog2(PID_CNT_W);

  typedef struct packed {
    logic                  advance;
    logic                  armed;
    logic [PID_SPAN_W-1:0] spanBits;
  } pid_strobe_t;
endpackage

// File: rtl/pid_rate_ctrl.sv
module pid_rate_ctrl
  import pid_pkg::*;
#(
  parameter int ALIAS_LIMIT = 2,
  parameter int ALIAS_ADD   = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tickIn,
  input  logic [PID_CODE_W-1:0] rateCode,
  input  logic                  periodicEn,
  output pid_strobe_t           strobes
);
  localparam int SW = PID_SPAN_W;

  logic [SW-1:0] effCode;

  always_comb begin
    if (rateCode <= PID_CODE_W'(ALIAS_LIMIT))
      effCode = SW'(rateCode) + SW'(ALIAS_ADD);
    else
      effCode = SW'(rateCode);
    strobes.advance  = tickIn;
    strobes.armed    = periodicEn && (rateCode != '0);
    strobes.spanBits = effCode - SW'(1);
  end

  // R4: when armed, the boundary width stays within the counter
  a_r4_span_in_range: assert property (@(posedge clk) disable iff (rst)
    strobes.armed |-> (strobes.spanBits >= SW'(2)) && (strobes.spanBits <= SW'(PID_CNT_W - 1)));
endmodule

// File: rtl/pid_tick_datapath.sv
module pid_tick_datapath
  import pid_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  pid_strobe_t strobes,
  output logic        eventOut
);
  localparam int CW = PID_CNT_W;
  localparam int SW = PID_SPAN_W;

  logic [CW-1:0] tickCount;
  logic [CW-1:0] nextCount;
  logic [CW-1:0] lowMask;
  logic          hit;

  for (genvar b = 0; b < CW; b++) begin : g_mask
    assign lowMask[b] = (SW'(b) < strobes.spanBits);
  end

  always_comb begin
    nextCount = tickCount + CW'(1);
    hit = strobes.advance && strobes.armed && ((nextCount & lowMask) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCount <= '0;
      eventOut  <= 1'b0;
    end else begin
      if (strobes.advance) tickCount <= nextCount;
      eventOut <= hit;
    end
  end

  // R8: the counter holds between ticks
  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !strobes.advance |=> $stable(tickCount));
  // R8: the counter steps by one (wrapping) on each tick
  a_r8_step_on_tick: assert property (@(posedge clk) disable iff (rst)
    strobes.advance |=> tickCount == CW'($past(tickCount) + CW'(1)));
  // R7: a pulse only follows a tick
  a_r7_pulse_after_tick: assert property (@(posedge clk) disable iff (rst)
    eventOut |-> $past(strobes.advance));
  // R6: a pulse only lands on a period boundary
  a_r6_on_boundary: assert property (@(posedge clk) disable iff (rst)
    eventOut |-> ((tickCount & $past(lowMask)) == '0));
endmodule

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider
  import pid_pkg::*;
#(
  parameter int ALIAS_LIMIT = 2,
  parameter int ALIAS_ADD   = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tickIn,
  input  logic [PID_CODE_W-1:0] rateCode,
  input  logic                  periodicEn,
  output logic                  eventOut
);
  pid_strobe_t strobes;

  pid_rate_ctrl #(
    .ALIAS_LIMIT(ALIAS_LIMIT),
    .ALIAS_ADD  (ALIAS_ADD)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .tickIn    (tickIn),
    .rateCode  (rateCode),
    .periodicEn(periodicEn),
    .strobes   (strobes)
  );

  pid_tick_datapath dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .eventOut(eventOut)
  );

  // R3: no pulse unless enabled at the tick
  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    eventOut |-> $past(periodicEn));
  // R2: no pulse for a zero rate code
  a_r2_quiet_code_zero: assert property (@(posedge clk) disable iff (rst)
    eventOut |-> ($past(rateCode) != '0));
endmodule

// File: tb/periodic_irq_divider_tb_top.sv
`timescale 1ns/1ps
module periodic_irq_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickIn = 1'b0;
  logic [3:0] rateCode = 4'd0;
  logic       periodicEn = 1'b0;
  logic       eventOut;

  int checks = 0;
  int fails = 0;
  int eventsSeen = 0;
  bit finished = 1'b0;
  logic [14:0] modelCount = '0;

  always #2.5 clk = ~clk;

  periodic_irq_divider dut_i (
    .clk(clk), .rst(rst), .tickIn(tickIn), .rateCode(rateCode),
    .periodicEn(periodicEn), .eventOut(eventOut)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic expectHit(logic [14:0] nxt, logic [3:0] code, logic en);
    int e;
    logic [14:0] m;
    if (!en || code == 4'd0) return 1'b0;
    e = (code <= 4'd2) ? int'(code) + 7 : int'(code);
    m = 15'((1 << (e - 1)) - 1);
    return (nxt & m) == 15'd0;
  endfunction

  function automatic string tagFor(logic [3:0] code, logic en);
    if (code == 4'd0) return "R2";
    if (!en) return "R3";
    if (code <= 4'd2) return "R5";
    return "R4";
  endfunction

  task automatic doTick(int gap, string tag);
    logic exp;
    logic [14:0] nxt;
    @(negedge clk);
    tickIn = 1'b1;
    nxt = modelCount + 15'd1;
    exp = expectHit(nxt, rateCode, periodicEn);
    @(negedge clk);
    tickIn = 1'b0;
    modelCount = nxt;
    if (eventOut === 1'b1) eventsSeen++;
    check(eventOut === exp, tag, int'(eventOut), int'(exp));
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      check(eventOut === 1'b0, "R7", int'(eventOut), 0);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R7 actual=0 expected=1");
      report();
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd20240611));
    // R1: ticks during reset are ignored, output low
    rateCode = 4'd3;
    periodicEn = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tickIn = 1'b1;
      @(negedge clk); tickIn = 1'b0;
      check(eventOut === 1'b0, "R1", int'(eventOut), 0);
    end
    @(negedge clk);
    rst = 1'b0;
    check(eventOut === 1'b0, "R1", int'(eventOut), 0);
    base = eventsSeen;
    for (int i = 0; i < 3; i++) doTick(1, "R1");
    check(eventsSeen == base, "R1", eventsSeen - base, 0);
    doTick(1, "R1");
    check(eventsSeen == base + 1, "R1", eventsSeen - base, 1);

    // R4: each direct code over two periods
    for (int c = 3; c <= 8; c++) begin
      rateCode = 4'(c);
      for (int i = 0; i < (1 << c); i++) doTick(0, "R4");
    end

    // R5: aliased codes 1 and 2
    for (int c = 1; c <= 2; c++) begin
      rateCode = 4'(c);
      base = eventsSeen;
      for (int i = 0; i < 512; i++) doTick(0, "R5");
      check(eventsSeen - base == ((c == 1) ? 4 : 2), "R5", eventsSeen - base, (c == 1) ? 4 : 2);
    end

    // R2: code zero never fires
    rateCode = 4'd0;
    periodicEn = 1'b1;
    base = eventsSeen;
    for (int i = 0; i < 300; i++) doTick(0, "R2");
    check(eventsSeen == base, "R2", eventsSeen - base, 0);

    // R3: disabled never fires
    rateCode = 4'd3;
    periodicEn = 1'b0;
    base = eventsSeen;
    for (int i = 0; i < 300; i++) doTick(0, "R3");
    check(eventsSeen == base, "R3", eventsSeen - base, 0);

    // R6: enable part-way, first event at next multiple of 8
    while (modelCount[2:0] != 3'd5) doTick(0, "R3");
    rateCode = 4'd4;
    periodicEn = 1'b1;
    base = eventsSeen;
    doTick(0, "R6");
    doTick(0, "R6");
    check(eventsSeen == base, "R6", eventsSeen - base, 0);
    doTick(0, "R6");
    check(eventsSeen == base + 1, "R6", eventsSeen - base, 1);

    // R9: switch rate mid-period, new boundary applies at once
    while (modelCount[4:0] != 5'd12) doTick(0, "R9");
    rateCode = 4'd3;
    doTick(0, "R9");
    rateCode = 4'd6;
    for (int i = 0; i < 70; i++) doTick(0, "R9");
    periodicEn = 1'b0;
    doTick(0, "R9");
    periodicEn = 1'b1;
    rateCode = 4'd3;
    for (int i = 0; i < 8; i++) doTick(0, "R9");

    // R8: full wrap at slowest rate gives exactly two events
    rateCode = 4'd15;
    periodicEn = 1'b1;
    base = eventsSeen;
    for (int i = 0; i < 32768; i++) doTick(0, "R8");
    check(eventsSeen - base == 2, "R8", eventsSeen - base, 2);

    // Random segments: code, enable and tick spacing
    for (int s = 0; s < 40; s++) begin
      int n;
      rateCode = 4'($urandom_range(0, 15));
      periodicEn = ($urandom_range(0, 3) != 0);
      n = int'($urandom_range(1, 400));
      for (int i = 0; i < n; i++)
        doTick(int'($urandom_range(0, 2)), tagFor(rateCode, periodicEn));
    end

    finished = 1'b1;
    report();
    $finish;
  end
endmodule